// File: doc/BRIEF.md
# Region-Based I/O Wait-State Controller

This block runs a dedicated peripheral address space of 2048 words. The core reaches it only through separate I/O read and write operations. The top two bits of the 11-bit I/O address split that space into four regions of 512 words. Each region has its own programmable wait count of 0 to 7 cycles, which the block inserts automatically into every access that lands in that region. While an access runs, the block drives the external address, the I/O select, and a read or write strobe. It answers the core with a ready signal, and the core treats ready low as a stall.

The block also builds a composite select output from the select lines of the program, data and boot spaces plus its own I/O select. A mask register chooses which of those lines take part. The composite output is a purely combinational OR of the enabled lines, so it rises and falls in the same cycle as they do. A small write port loads the four wait registers and the mask.

Top module: `iows_ctrl`

## Requirements
- R1: I/O address bits 10:9 pick the region: 0 selects wait register 0 (0x000–0x1FF), 1 selects register 1 (0x200–0x3FF), 2 selects register 2 (0x400–0x5FF) and 3 selects register 3 (0x600–0x7FF).
- R2: When the core holds `io_req` on a region whose wait value is W (W ≥ 1), `io_ready` is low for the first W cycles and high in cycle W+1.
- R3: When W is 0, `io_ready` is high in the same cycle as the first strobe cycle.
- R4: `io_sel` equals `io_req` in the same cycle. `io_rd` is high only while `io_req` is high and `io_write` is 0. `io_wr` is high only while `io_req` is high and `io_write` is 1. All three are low without a request.
- R5: While `io_req` is high, `ext_addr[10:0]` equals `io_addr` and `ext_addr[13:11]` is 0. Without a request, `ext_addr` is all zero.
- R6: After reset, every wait register holds 7 and the composite mask is 0, so `comp_sel` stays low whatever the select inputs do.
- R7: A cycle with `cfg_we` high loads one register from `cfg_wdata`:
  - `cfg_addr` 0 to 3 writes wait register 0 to 3 from `cfg_wdata[2:0]`.
  - `cfg_addr` 4 writes the mask from `cfg_wdata[3:0]`. Bit 0 enables program, bit 1 data, bit 2 boot and bit 3 I/O.
  - `cfg_addr` 5 to 7 changes nothing.
- R8: `comp_sel` is high in exactly those cycles in which at least one enabled select line is high, with no added latency.
- R9: The wait count is captured in the first cycle of an access. A change to that region's register during the access does not change the length of that access, but it does apply to the next one.
- R10: A new access may start in the cycle right after `io_ready` is high. It gets its own full wait count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register select (0–3 wait registers, 4 mask) |
| cfg_wdata | input | 4 | Register write data |
| io_req | input | 1 | I/O access request, held by the core until ready |
| io_write | input | 1 | 1 for a write access, 0 for a read access |
| io_addr | input | 11 | I/O word address |
| io_sel | output | 1 | I/O space select |
| io_rd | output | 1 | Read strobe |
| io_wr | output | 1 | Write strobe |
| io_ready | output | 1 | Access completes in this cycle; low means stall |
| ext_addr | output | 14 | External address bus |
| prog_sel | input | 1 | Program-space select from its decoder |
| data_sel | input | 1 | Data-space select from its decoder |
| boot_sel | input | 1 | Boot-space select from its decoder |
| comp_sel | output | 1 | Composite select |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a stalled access to the same region. Only the captured count may govern that access, and the new value must govern the following one. The bench starts a seven-wait access and writes 0 to that region's register in the access's second cycle. It then checks that ready still arrives in cycle eight, and that the next access to the region completes in one cycle. Back-to-back accesses with no idle cycle between them are driven as well, to show that every access reloads its own count.

// File: rtl/iows_pkg.sv
package iows_pkg;
   // Bit positions of the composite-select mask
   localparam int SEL_PROG = 0;
   localparam int SEL_DATA = 1;
   localparam int SEL_BOOT = 2;
   localparam int SEL_IO   = 3;
   localparam int NSEL     = 4;

   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_WAIT = 1'b1
   } tmr_state_e;
endpackage

// File: rtl/iows_cfg_regs.sv
module iows_cfg_regs #(
   parameter int NREGION = 4,
   parameter int WAIT_W  = 3,
   parameter int NSEL    = 4,
   parameter int CFG_AW  = 3,
   parameter int CFG_DW  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [CFG_AW-1:0]          addr,
   input  logic [CFG_DW-1:0]          wdata,
   output logic [NREGION*WAIT_W-1:0]  wait_flat,
   output logic [NSEL-1:0]            mask
);
   localparam int MASK_IDX = NREGION;

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^wdata;

   for (genvar g = 0; g < NREGION; g++) begin : g_wreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wait_flat[g*WAIT_W +: WAIT_W] <= '1;
         else if (we && (int'(addr) == g))
            wait_flat[g*WAIT_W +: WAIT_W] <= wdata[WAIT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask <= '0;
      else if (we && (int'(addr) == MASK_IDX))
         mask <= wdata[NSEL-1:0];
   end

   // R6: registers leave reset at maximum wait and an empty mask
   p_reset_state_r6: assert property (@(posedge clk)
      !rst_n |=> (mask == '0) && (&wait_flat));

   // R7: a write to an unmapped register changes no state
   p_unmapped_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(addr) > MASK_IDX) |=> $stable(mask) && $stable(wait_flat));
endmodule

// File: rtl/iows_region_decode.sv
module iows_region_decode #(
   parameter int ADDR_W  = 11,
   parameter int NREGION = 4,
   parameter int WAIT_W  = 3
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NREGION*WAIT_W-1:0]  wait_flat,
   output logic [WAIT_W-1:0]          wait_sel
);
   localparam int RB = (NREGION > 1) ? $clog2(NREGION) : 1;

   if (NREGION == 1) begin : g_single
      logic unused_addr;
      assign unused_addr = ^addr;
      assign wait_sel = wait_flat;
   end else begin : g_multi
      logic [RB-1:0] region;
      logic unused_low;
      assign region = addr[ADDR_W-1 -: RB];
      assign unused_low = ^addr[ADDR_W-RB-1:0];
      always_comb begin
         wait_sel = '0;
         for (int i = 0; i < NREGION; i++)
            if (int'(region) == i) wait_sel = wait_flat[i*WAIT_W +: WAIT_W];
      end
   end
endmodule

// File: rtl/iows_wait_timer.sv
module iows_wait_timer
   import iows_pkg::*;
#(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [WAIT_W-1:0] wait_val,
   output logic              ready,
   output logic              busy
);
   tmr_state_e        state;
   logic [WAIT_W-1:0] cnt;

   assign busy = (state == TMR_WAIT);

   always_comb begin
      ready = 1'b0;
      if (busy)     ready = (cnt == '0);
      else if (req) ready = (wait_val == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TMR_IDLE;
         cnt   <= '0;
      end else if (busy) begin
         if (cnt == '0) state <= TMR_IDLE;
         else           cnt   <= cnt - 1'b1;
      end else if (req && wait_val != '0) begin
         state <= TMR_WAIT;
         cnt   <= wait_val - 1'b1;
      end
   end

   // R3: zero wait completes in the strobe's first cycle
   p_zero_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && wait_val == '0) |-> ready);

   // R2: no ready while a count is still pending
   p_no_early_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |-> !ready);

   // R10: completion returns to idle so the next access reloads
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ready) |=> !busy);

   // R2: the core keeps requesting while stalled
   p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> req);
endmodule

// File: rtl/iows_comp_select.sv
module iows_comp_select #(
   parameter int NSEL = 4
) (
   input  logic [NSEL-1:0] sel_in,
   input  logic [NSEL-1:0] mask,
   output logic            comp
);
   logic [NSEL-1:0] term;

   for (genvar g = 0; g < NSEL; g++) begin : g_term
      assign term[g] = sel_in[g] & mask[g];
   end

   assign comp = |term;
endmodule

// File: rtl/iows_ctrl.sv
module iows_ctrl
   import iows_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int EXT_W   = 14,
   parameter int NREGION = 4,
   parameter int WAIT_W  = 3,
   parameter int CFG_AW  = 3,
   parameter int CFG_DW  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic              io_req,
   input  logic              io_write,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              io_sel,
   output logic              io_rd,
   output logic              io_wr,
   output logic              io_ready,
   output logic [EXT_W-1:0]  ext_addr,
   input  logic              prog_sel,
   input  logic              data_sel,
   input  logic              boot_sel,
   output logic              comp_sel
);
   if ((1 << CFG_AW) <= NREGION) begin : g_bad_cfg_aw
      $error("cfg_addr cannot reach the mask register");
   end
   if (CFG_DW < WAIT_W || CFG_DW < NSEL) begin : g_bad_cfg_dw
      $error("cfg_wdata too narrow");
   end
   if (EXT_W < ADDR_W) begin : g_bad_ext
      $error("external bus narrower than I/O address");
   end
   if (NREGION < 1 || (NREGION & (NREGION - 1)) != 0) begin : g_bad_nreg
      $error("region count must be a power of two");
   end

   logic [NREGION*WAIT_W-1:0] wait_flat;
   logic [NSEL-1:0]           mask;
   logic [WAIT_W-1:0]         wait_sel;
   logic                      busy;
   logic [NSEL-1:0]           sel_vec;

   iows_cfg_regs #(
      .NREGION(NREGION), .WAIT_W(WAIT_W), .NSEL(NSEL),
      .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .wait_flat(wait_flat), .mask(mask)
   );

   iows_region_decode #(
      .ADDR_W(ADDR_W), .NREGION(NREGION), .WAIT_W(WAIT_W)
   ) u_dec (
      .addr(io_addr), .wait_flat(wait_flat), .wait_sel(wait_sel)
   );

   iows_wait_timer #(.WAIT_W(WAIT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .req(io_req), .wait_val(wait_sel),
      .ready(io_ready), .busy(busy)
   );

   assign io_sel = io_req;
   assign io_rd  = io_req & ~io_write;
   assign io_wr  = io_req &  io_write;

   if (EXT_W > ADDR_W) begin : g_pad
      assign ext_addr = io_req ? {{(EXT_W-ADDR_W){1'b0}}, io_addr} : '0;
   end else begin : g_nopad
      assign ext_addr = io_req ? io_addr : '0;
   end

   always_comb begin
      sel_vec           = '0;
      sel_vec[SEL_PROG] = prog_sel;
      sel_vec[SEL_DATA] = data_sel;
      sel_vec[SEL_BOOT] = boot_sel;
      sel_vec[SEL_IO]   = io_sel;
   end

   iows_comp_select #(.NSEL(NSEL)) u_comp (
      .sel_in(sel_vec), .mask(mask), .comp(comp_sel)
   );

   // Checker state: cycles spent in an access versus the captured count
   logic [WAIT_W:0]   chk_elapsed;
   logic [WAIT_W-1:0] chk_wait;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_elapsed <= '0;
         chk_wait    <= '0;
      end else if (!busy && io_req) begin
         chk_elapsed <= 1;
         chk_wait    <= wait_sel;
      end else if (busy) begin
         chk_elapsed <= chk_elapsed + 1'b1;
      end
   end

   // R2/R9: ready arrives after exactly the count captured at the start
   p_wait_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && io_ready) |-> (chk_elapsed == {1'b0, chk_wait}));

   // R4: read and write strobes never overlap
   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_wr));

   // R8: an enabled I/O select shows on the composite in the same cycle
   p_comp_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel && mask[SEL_IO]) |-> comp_sel);

   // R8: composite never asserts without some select active
   p_comp_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      comp_sel |-> (prog_sel || data_sel || boot_sel || io_sel));

   // R5: address held steady while an access stalls
   p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(io_addr));
endmodule

// File: tb/iows_ctrl_test.sv
module iows_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [3:0]  cfg_wdata = '0;
   logic        io_req = 1'b0;
   logic        io_write = 1'b0;
   logic [10:0] io_addr = '0;
   logic        io_sel, io_rd, io_wr, io_ready, comp_sel;
   logic [13:0] ext_addr;
   logic        prog_sel = 1'b0, data_sel = 1'b0, boot_sel = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   iows_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .io_req(io_req), .io_write(io_write),
      .io_addr(io_addr), .io_sel(io_sel), .io_rd(io_rd), .io_wr(io_wr),
      .io_ready(io_ready), .ext_addr(ext_addr), .prog_sel(prog_sel),
      .data_sel(data_sel), .boot_sel(boot_sel), .comp_sel(comp_sel)
   );

   // {addr[10:0], write, expected cycles[3:0]}; waits set to 2,0,7,4
   localparam logic [15:0] VEC [10] = '{
      {11'h000, 1'b0, 4'd3}, {11'h1FF, 1'b1, 4'd3},
      {11'h200, 1'b0, 4'd1}, {11'h3FF, 1'b1, 4'd1},
      {11'h400, 1'b0, 4'd8}, {11'h5FF, 1'b1, 4'd8},
      {11'h600, 1'b0, 4'd5}, {11'h7FF, 1'b1, 4'd5},
      {11'h123, 1'b0, 4'd3}, {11'h6A5, 1'b1, 4'd5}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [3:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Called just after a falling edge; leaves at the falling edge after ready
   task automatic access(input logic [10:0] a, input logic w, input int exp_cyc);
      int n;
      bit strobe_ok;
      io_req = 1'b1; io_addr = a; io_write = w;
      n = 1;
      strobe_ok = 1'b1;
      forever begin
         #1;
         if (io_sel !== 1'b1 || io_rd !== !w || io_wr !== w) strobe_ok = 1'b0;
         if (n == 1)
            check(ext_addr === {3'b000, a}, "R5 ext_addr during access",
                  int'(ext_addr), int'({3'b000, a}));
         if (io_ready === 1'b1) break;
         if (n > 20) break;
         @(negedge clk);
         n++;
      end
      check(strobe_ok, "R4 strobes during access", int'(strobe_ok), 1);
      check(n == exp_cyc, "R1/R2/R3 access length", n, exp_cyc);
      @(negedge clk);
      io_req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: empty mask keeps composite low, all waits at 7
      prog_sel = 1; data_sel = 1; boot_sel = 1;
      #1;
      check(comp_sel === 1'b0, "R6 composite after reset", int'(comp_sel), 0);
      check(io_sel === 1'b0 && io_rd === 1'b0 && io_wr === 1'b0 && ext_addr === '0,
            "R4/R5 idle outputs", int'(ext_addr), 0);
      prog_sel = 0; data_sel = 0; boot_sel = 0;
      @(negedge clk);
      access(11'h000, 1'b0, 8);
      access(11'h7FF, 1'b1, 8);

      // R7: program region waits 2,0,7,4
      cfg_write(3'd0, 4'd2);
      cfg_write(3'd1, 4'd0);
      cfg_write(3'd2, 4'd7);
      cfg_write(3'd3, 4'd4);
      @(negedge clk);

      for (int i = 0; i < 10; i++) begin
         access(VEC[i][15:5], VEC[i][4], int'(VEC[i][3:0]));
         @(negedge clk);
      end

      // R10: back-to-back accesses with no idle cycle between
      access(11'h000, 1'b0, 3);
      access(11'h650, 1'b1, 5);
      access(11'h210, 1'b0, 1);
      access(11'h211, 1'b1, 1);

      // R7: writes to 5..7 ignored; mask and waits unchanged
      cfg_write(3'd5, 4'hF);
      cfg_write(3'd6, 4'h0);
      cfg_write(3'd7, 4'h0);
      prog_sel = 1; data_sel = 1; boot_sel = 1;
      #1;
      check(comp_sel === 1'b0, "R7 unmapped write leaves mask", int'(comp_sel), 0);
      prog_sel = 0; data_sel = 0; boot_sel = 0;
      @(negedge clk);
      access(11'h0AA, 1'b0, 3);
      access(11'h2AA, 1'b0, 1);
      access(11'h4AA, 1'b0, 8);
      access(11'h6AA, 1'b0, 5);

      // R8: composite follows enabled selects combinationally
      for (int m = 0; m < 16; m += 5) begin
         cfg_write(3'd4, 4'(m));
         for (int s = 0; s < 16; s += 3) begin
            logic [3:0] sv;
            bit exp_c;
            sv = 4'(s);
            prog_sel = sv[0]; data_sel = sv[1]; boot_sel = sv[2];
            io_req = sv[3]; io_addr = 11'h200; io_write = 1'b0;
            exp_c = |(sv & 4'(m));
            #1;
            check(comp_sel === exp_c, "R8 composite select", int'(comp_sel), int'(exp_c));
            @(negedge clk);
            io_req = 1'b0;
         end
      end
      prog_sel = 0; data_sel = 0; boot_sel = 0;

      // R9: mid-access write to the same region does not shorten it
      begin
         int n;
         io_req = 1'b1; io_addr = 11'h480; io_write = 1'b1;
         n = 1;
         forever begin
            #1;
            if (io_ready === 1'b1 || n > 20) break;
            @(negedge clk);
            n++;
            if (n == 2) begin cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 4'd0; end
            if (n == 3) cfg_we = 1'b0;
         end
         check(n == 8, "R9 captured wait length", n, 8);
         @(negedge clk);
         io_req = 1'b0;
         cfg_we = 1'b0;
      end
      @(negedge clk);
      access(11'h480, 1'b0, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule